// File: doc/BRIEF.md
# WLAN/Bluetooth Coexistence Arbiter

This block lives on the WLAN side of a shared 2.4 GHz front end. It decides whether a co-located Bluetooth radio may use the medium for each of its slots. The Bluetooth device raises a request line for the length of each transmit or receive slot. In the 3-wire arrangement it also drives a priority line. The block answers on a single activity line: high means the slot is refused, low means Bluetooth may go ahead.

Both Bluetooth inputs are asynchronous, so each passes through a synchronizer chain. The decision is taken once, on the synchronized rising edge of the request, and it is frozen until the request drops. In 2-wire mode only WLAN activity counts. In 3-wire mode a high-priority request overrides WLAN traffic unless WLAN has flagged the exchange as one that must not be interrupted. An antenna-switch output follows the grant, or it can be forced directly by configuration. A configuration bit switches coexistence off entirely.

Top module: `coex_arbiter`

## Requirements
- R1: While reset is held and on leaving reset, no Bluetooth decision is held, `wl_act_out` equals `cfg_enable & wl_busy`, and `ant_sw_out` equals `cfg_ant_bypass ? cfg_ant_sel : 0`.
- R2: A rise on `bt_req_in` takes effect on the third rising clock edge after it is sampled. Until that edge, `wl_act_out` still follows `wl_busy`.
- R3: In 2-wire mode (`cfg_three_wire` = 0), the slot is denied exactly when `wl_busy` is high at the decision edge, and `bt_pri_in` has no effect on the outcome.
- R4: In 3-wire mode, a normal-priority request (`bt_pri_in` = 0) is denied exactly when `wl_busy` is high at the decision edge.
- R5: In 3-wire mode, a high-priority request (`bt_pri_in` = 1) is granted even while `wl_busy` is high, and it is denied only when `wl_protect` is high at the decision edge.
- R6: Once taken, the decision stays unchanged while the request stays high, whatever `wl_busy`, `wl_protect` or `bt_pri_in` do.
- R7: A fall on `bt_req_in` releases the held decision on the third rising clock edge after it is sampled.
- R8: While `cfg_enable` is 0, `wl_act_out` is 0 at all times, and this applies in the same cycle that `cfg_enable` falls.
- R9: With `cfg_ant_bypass` = 1, `ant_sw_out` equals `cfg_ant_sel`. Otherwise `ant_sw_out` is 1 exactly while coexistence is enabled and a granted Bluetooth slot is held, and 0 at all other times.
- R10: With coexistence enabled and no Bluetooth decision held, `wl_act_out` follows `wl_busy` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Coexistence on (1) or off (0) |
| cfg_three_wire | input | 1 | 1 selects 3-wire mode, 0 selects 2-wire mode |
| cfg_ant_bypass | input | 1 | 1 forces the antenna switch from `cfg_ant_sel` |
| cfg_ant_sel | input | 1 | Forced antenna-switch value |
| wl_busy | input | 1 | WLAN is transmitting or receiving |
| wl_protect | input | 1 | WLAN exchange must not be interrupted |
| bt_req_in | input | 1 | Asynchronous Bluetooth slot request |
| bt_pri_in | input | 1 | Asynchronous Bluetooth priority, 1 means high |
| wl_act_out | output | 1 | 1 means deny or WLAN active, 0 means Bluetooth may use the medium |
| ant_sw_out | output | 1 | Antenna switch, 1 selects the Bluetooth side |

## Verification
The bench drives inputs on the falling edge. It samples the outputs one half cycle after the second rising edge, to confirm that the old behaviour is still in place (R2), and again after the third rising edge, where the latched decision first appears. Release is checked the same way: two edges after the request drops the decision must still be held, and after the third edge it must be gone. Configuration and WLAN-status effects on an idle arbiter are combinational, so those checks sample in the same half cycle. Randomized slots draw the mode, priority, busy, protect and bypass values from a seeded generator, and a bench function predicts the outcome.

// File: rtl/coex_arbiter.sv
module coex_arbiter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_enable,
  input  logic cfg_three_wire,
  input  logic cfg_ant_bypass,
  input  logic cfg_ant_sel,
  input  logic wl_busy,
  input  logic wl_protect,
  input  logic bt_req_in,
  input  logic bt_pri_in,
  output logic wl_act_out,
  output logic ant_sw_out
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] req_sync, pri_sync;
  logic req_seen, slot_held, slot_deny;

  wire req_now  = req_sync[TOP];
  wire pri_now  = pri_sync[TOP];
  wire req_rise = req_now & ~req_seen;
  wire decide   = (cfg_three_wire & pri_now) ? wl_protect : wl_busy;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          req_sync <= '0;
          pri_sync <= '0;
        end else begin
          req_sync <= bt_req_in;
          pri_sync <= bt_pri_in;
        end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          req_sync <= '0;
          pri_sync <= '0;
        end else begin
          req_sync <= {req_sync[TOP-1:0], bt_req_in};
          pri_sync <= {pri_sync[TOP-1:0], bt_pri_in};
        end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      req_seen  <= 1'b0;
      slot_held <= 1'b0;
      slot_deny <= 1'b0;
    end else begin
      req_seen <= req_now;
      if (req_rise) begin
        slot_held <= 1'b1;
        slot_deny <= decide;
      end else if (!req_now) begin
        slot_held <= 1'b0;
        slot_deny <= 1'b0;
      end
    end

  assign wl_act_out = cfg_enable & (slot_held ? slot_deny : wl_busy);
  assign ant_sw_out = cfg_ant_bypass ? cfg_ant_sel
                                     : (cfg_enable & slot_held & ~slot_deny);

  a_r2_latch_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    req_rise |=> slot_held);

  a_r3_two_wire_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rise && !cfg_three_wire) |=> (slot_deny == $past(wl_busy)));

  a_r5_high_pri_protect: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rise && cfg_three_wire && pri_now) |=> (slot_deny == $past(wl_protect)));

  a_r6_decision_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_held && $past(slot_held)) |-> $stable(slot_deny));

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    !req_now |=> !slot_held);

  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |-> !wl_act_out);

endmodule

// File: tb/coex_arbiter_tb.sv
module coex_arbiter_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_enable = 1'b1, cfg_three_wire = 1'b0, cfg_ant_bypass = 1'b0, cfg_ant_sel = 1'b0;
  logic wl_busy = 1'b0, wl_protect = 1'b0, bt_req_in = 1'b0, bt_pri_in = 1'b0;
  logic wl_act_out, ant_sw_out;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coex_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_three_wire(cfg_three_wire),
    .cfg_ant_bypass(cfg_ant_bypass), .cfg_ant_sel(cfg_ant_sel), .wl_busy(wl_busy),
    .wl_protect(wl_protect), .bt_req_in(bt_req_in), .bt_pri_in(bt_pri_in),
    .wl_act_out(wl_act_out), .ant_sw_out(ant_sw_out));

  function automatic bit exp_deny(bit three, bit pri, bit busy, bit prot);
    return (three && pri) ? prot : busy;
  endfunction

  task automatic check(string req, logic act, logic exp_act, logic ant, logic exp_ant);
    checks++;
    if (act !== exp_act || ant !== exp_ant) begin
      failures++;
      $display("FAIL %s: act=%b ant=%b expected act=%b ant=%b", req, act, ant, exp_act, exp_ant);
    end
  endtask

  function automatic bit idle_ant();
    return cfg_ant_bypass ? cfg_ant_sel : 1'b0;
  endfunction

  task automatic run_slot(bit en, bit three, bit pri, bit busy, bit prot, bit byp, bit sel);
    bit d, gnt_ant;
    @(negedge clk);
    cfg_enable = en; cfg_three_wire = three; cfg_ant_bypass = byp; cfg_ant_sel = sel;
    wl_busy = busy; wl_protect = prot; bt_pri_in = pri; bt_req_in = 1'b1;
    d = exp_deny(three, pri, busy, prot);
    gnt_ant = byp ? sel : (en & ~d);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R2 pre-decision", wl_act_out, en & busy, ant_sw_out, idle_ant());
    @(posedge clk);
    @(negedge clk);
    if (!en) check("R8 disabled slot", wl_act_out, 1'b0, ant_sw_out, gnt_ant);
    else if (!three) check("R3 two-wire decision", wl_act_out, d, ant_sw_out, gnt_ant);
    else if (pri) check("R5 high-priority decision", wl_act_out, d, ant_sw_out, gnt_ant);
    else check("R4 normal-priority decision", wl_act_out, d, ant_sw_out, gnt_ant);
    wl_busy = ~busy; wl_protect = ~prot; bt_pri_in = ~pri;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6 decision held", wl_act_out, en & d, ant_sw_out, gnt_ant);
    bt_req_in = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R7 still held before release", wl_act_out, en & d, ant_sw_out, gnt_ant);
    @(posedge clk);
    @(negedge clk);
    check("R7 released", wl_act_out, en & wl_busy, ant_sw_out, idle_ant());
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: act=%b ant=%b expected act=x ant=x", wl_act_out, ant_sw_out);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", wl_act_out, 1'b0, ant_sw_out, 1'b0);
    wl_busy = 1'b1;
    #1 check("R1 in reset busy", wl_act_out, 1'b1, ant_sw_out, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1 after reset", wl_act_out, 1'b1, ant_sw_out, 1'b0);
    wl_busy = 1'b0;
    #1 check("R10 idle follows busy", wl_act_out, 1'b0, ant_sw_out, 1'b0);
    wl_busy = 1'b1; cfg_enable = 1'b0;
    #1 check("R8 disabled idle", wl_act_out, 1'b0, ant_sw_out, 1'b0);
    cfg_enable = 1'b1; cfg_ant_bypass = 1'b1; cfg_ant_sel = 1'b1;
    #1 check("R9 bypass idle", wl_act_out, 1'b1, ant_sw_out, 1'b1);
    cfg_ant_bypass = 1'b0; cfg_ant_sel = 1'b0; wl_busy = 1'b0;

    run_slot(1, 0, 1, 1, 0, 0, 0);
    run_slot(1, 0, 1, 0, 1, 0, 0);
    run_slot(1, 1, 0, 1, 0, 0, 0);
    run_slot(1, 1, 0, 0, 1, 0, 0);
    run_slot(1, 1, 1, 1, 0, 0, 0);
    run_slot(1, 1, 1, 1, 1, 0, 0);
    run_slot(1, 1, 1, 0, 1, 1, 0);
    run_slot(0, 1, 1, 1, 0, 0, 0);

    @(negedge clk);
    cfg_enable = 1'b1; cfg_three_wire = 1'b0; wl_busy = 1'b1; bt_req_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R3 deny held", wl_act_out, 1'b1, ant_sw_out, 1'b0);
    cfg_enable = 1'b0;
    #1 check("R8 drop while held", wl_act_out, 1'b0, ant_sw_out, 1'b0);
    cfg_enable = 1'b1; bt_req_in = 1'b0;
    repeat (4) @(posedge clk);

    for (int i = 0; i < 60; i++) begin
      bit en, th, pr, bs, pt, by, sl;
      en = ($urandom % 8) != 0;
      th = $urandom; pr = $urandom; bs = $urandom; pt = $urandom;
      by = ($urandom % 4) == 0; sl = $urandom;
      run_slot(en, th, pr, bs, pt, by, sl);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule